// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block controls when a shadowed SRAM image moves into its nonvolatile cells (a store) and when it moves back (a recall). A recall runs by itself when reset ends. A store can be started in three ways: by a supply-fail comparator, by an external device pulling the shared active-low busy/request pad low, or by a software store command. A write latch records whether any write has been accepted since the last transfer completed. Supply-fail and pad requests need that latch to be set. A software command always runs.

While a transfer runs, the block holds the copy engine's run line high and drives its direction line. The copy is modelled as a fixed-latency handshake, with every duration counted in clock cycles. All host accesses are refused during a transfer. The block drives the busy pad low while a store it owns is pending. After a store it drives the pad strongly high for a short time and then releases it to the weak pull-up. A pad request opens a delay window before the store. A write already in flight when the pad falls still completes, and later writes are refused until the pad is seen high again.

Top module: `nv_xfer_seq`

## Requirements
- R1: When reset ends, a recall runs (xfer_run_o=1, xfer_dir_o=1; direction 1 means recall, 0 means store) for RECALL_CYC cycles, counting the reset state as its first cycle. The block then goes idle.
- R2: host_gnt_o stays low for every request while xfer_run_o is high.
- R3: In the idle state, reads and writes are granted in the same cycle as the request. A granted write sets dirty_o on the next clock edge. A read leaves dirty_o unchanged.
- R4: When pwr_fail_i is high in the idle state, the write latch is set and auto-store is enabled, the store begins on the next edge and lasts STORE_CYC cycles. With the latch clear, or with auto-store disabled, no transfer starts.
- R5: sw_store_i in the idle state starts a STORE_CYC-cycle store on the next edge, whether the latch is set or not.
- R6: A low on the synchronized busy pad while idle with the latch set opens a DELAY_CYC-cycle window, which is followed by the store. With the latch clear, the low pad starts nothing.
- R7: The pad input passes through SYNC_STAGES flops. A write request made before the low level has crossed the synchronizer is still granted. Once the low level has crossed it, writes are refused until the high level has crossed it again, while reads stay granted in the idle state and in the delay window.
- R8: busy_drv_lo_o is high during the delay window and the store only if the write latch is set; it is never high otherwise.
- R9: After every store, busy_drv_hi_o is high for HIGH_CYC cycles and then low. It never goes high after a recall.
- R10: A completed store or recall leaves dirty_o low.
- R11: Triggers are accepted only in the idle state. Supply-fail comes first, then software, then the pad. Simultaneous triggers produce exactly one store. A trigger raised while a sequence runs is dropped, not queued.
- R12: The auto-store enable register resets to 1. It is written with ase_wr_i/ase_wdata_i and read back on ase_o from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_fail_i | input | 1 | Supply-fail comparator level |
| sw_store_i | input | 1 | Software store command |
| busy_pin_i | input | 1 | Sensed level of the busy/request pad |
| busy_drv_lo_o | output | 1 | Open-drain pull-down enable for the pad |
| busy_drv_hi_o | output | 1 | Strong-high drive enable for the pad |
| ase_wr_i | input | 1 | Auto-store enable write strobe |
| ase_wdata_i | input | 1 | Auto-store enable write value |
| ase_o | output | 1 | Auto-store enable readback |
| host_req_i | input | 1 | Host array access request |
| host_we_i | input | 1 | Host access is a write |
| host_gnt_o | output | 1 | Host access granted this cycle |
| dirty_o | output | 1 | Write latch |
| xfer_run_o | output | 1 | Copy engine busy |
| xfer_dir_o | output | 1 | Copy direction, 1 recall, 0 store |

## Verification
Each store trigger is applied once with the write latch set and once with it clear. This separates the conditional triggers (supply-fail and pad) from the unconditional software command, and shows the pull-down following the latch rather than the trigger. The supply-fail trigger is also applied with auto-store disabled, to separate the enable register from the latch. Simultaneous triggers and a trigger injected in the middle of a store separate a single accepted sequence from a queued second one. The pad sequence is timed edge by edge, so a write granted during synchronizer latency is told apart from one refused after it, and the delay, store and strong-high intervals are each checked at their exact boundary cycles.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;

   typedef enum logic [2:0] {
      ST_RECALL = 3'd0,
      ST_IDLE   = 3'd1,
      ST_WAIT   = 3'd2,
      ST_STORE  = 3'd3,
      ST_HOLD   = 3'd4
   } nv_state_e;

   // bits needed to hold the values 0 .. n-1
   function automatic int nv_cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic int nv_max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/nv_sync_chain.sv
module nv_sync_chain #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("nv_sync_chain: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) s_q <= RST_VAL;
            else         s_q <= d_i;
         end
         assign q_o = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) s_q <= {STAGES{RST_VAL}};
            else         s_q <= {s_q[STAGES-2:0], d_i};
         end
         assign q_o = s_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nv_wlatch.sv
module nv_wlatch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   logic q_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_q <= 1'b0;
      else if (clr_i)  q_q <= 1'b0;
      else if (set_i)  q_q <= 1'b1;
   end

   assign q_o = q_q;

   AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !q_o); // R10

endmodule

// File: rtl/nv_countdown.sv
module nv_countdown #(
   parameter int W       = 4,
   parameter int RST_VAL = 0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= W'(RST_VAL);
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   AST_CNT_DESCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R1

endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
   import nv_xfer_pkg::*;
#(
   parameter int   DELAY_CYC   = 4,
   parameter int   STORE_CYC   = 16,
   parameter int   RECALL_CYC  = 12,
   parameter int   HIGH_CYC    = 3,
   parameter int   SYNC_STAGES = 2,
   parameter logic ASE_RST     = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwr_fail_i,
   input  logic sw_store_i,
   input  logic busy_pin_i,
   output logic busy_drv_lo_o,
   output logic busy_drv_hi_o,
   input  logic ase_wr_i,
   input  logic ase_wdata_i,
   output logic ase_o,
   input  logic host_req_i,
   input  logic host_we_i,
   output logic host_gnt_o,
   output logic dirty_o,
   output logic xfer_run_o,
   output logic xfer_dir_o
);

   localparam int MAX_CYC = nv_max4(DELAY_CYC, STORE_CYC, RECALL_CYC, HIGH_CYC);
   localparam int CW      = nv_cnt_w(MAX_CYC);

   generate
      if (DELAY_CYC < 1)  begin : g_bad_delay  $error("DELAY_CYC must be >= 1");  end
      if (STORE_CYC < 1)  begin : g_bad_store  $error("STORE_CYC must be >= 1");  end
      if (RECALL_CYC < 1) begin : g_bad_recall $error("RECALL_CYC must be >= 1"); end
      if (HIGH_CYC < 1)   begin : g_bad_high   $error("HIGH_CYC must be >= 1");   end
   endgenerate

   nv_state_e     state_q, state_d;
   logic          pin_hi;
   logic          tmr_zero;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          latch_clr;
   logic          latch_set;
   logic          ase_q;
   logic          pf_go, sw_go, pin_go;
   logic          rd_ok, wr_ok;

   // pad sense synchronizer
   nv_sync_chain #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_pin_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (busy_pin_i),
      .q_o    (pin_hi)
   );

   // interval timer, reset already loaded for the power-up recall
   nv_countdown #(
      .W       (CW),
      .RST_VAL (RECALL_CYC - 1)
   ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   // write latch
   nv_wlatch u_wlatch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (latch_set),
      .clr_i  (latch_clr),
      .q_o    (dirty_o)
   );

   // auto-store enable register
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ase_q <= ASE_RST;
      else if (ase_wr_i) ase_q <= ase_wdata_i;
   end
   assign ase_o = ase_q;

   // trigger qualification
   assign pf_go  = pwr_fail_i & ase_q & dirty_o;
   assign sw_go  = sw_store_i;
   assign pin_go = ~pin_hi & dirty_o;

   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      latch_clr = 1'b0;
      unique case (state_q)
         ST_RECALL: begin
            if (tmr_zero) begin
               state_d   = ST_IDLE;
               latch_clr = 1'b1;
            end
         end
         ST_IDLE: begin
            if (pf_go || sw_go) begin
               state_d  = ST_STORE;
               tmr_load = 1'b1;
               tmr_val  = CW'(STORE_CYC - 1);
            end else if (pin_go) begin
               state_d  = ST_WAIT;
               tmr_load = 1'b1;
               tmr_val  = CW'(DELAY_CYC - 1);
            end
         end
         ST_WAIT: begin
            if (tmr_zero) begin
               state_d  = ST_STORE;
               tmr_load = 1'b1;
               tmr_val  = CW'(STORE_CYC - 1);
            end
         end
         ST_STORE: begin
            if (tmr_zero) begin
               state_d   = ST_HOLD;
               tmr_load  = 1'b1;
               tmr_val   = CW'(HIGH_CYC - 1);
               latch_clr = 1'b1;
            end
         end
         ST_HOLD: begin
            if (tmr_zero) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_RECALL;
      else         state_q <= state_d;
   end

   // host access gating
   assign rd_ok      = (state_q == ST_IDLE) || (state_q == ST_WAIT) || (state_q == ST_HOLD);
   assign wr_ok      = ((state_q == ST_IDLE) || (state_q == ST_HOLD)) && pin_hi;
   assign host_gnt_o = host_req_i && (host_we_i ? wr_ok : rd_ok);
   assign latch_set  = host_gnt_o && host_we_i;

   // copy engine and pad drive
   assign xfer_run_o    = (state_q == ST_STORE) || (state_q == ST_RECALL);
   assign xfer_dir_o    = (state_q == ST_RECALL);
   assign busy_drv_lo_o = ((state_q == ST_WAIT) || (state_q == ST_STORE)) && dirty_o;
   assign busy_drv_hi_o = (state_q == ST_HOLD);

   AST_NO_ACCESS_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xfer_run_o |-> !host_gnt_o); // R2
   AST_NO_WRITE_PIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pin_hi |-> !(host_gnt_o && host_we_i)); // R7
   AST_CLEAN_NO_PULLDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dirty_o |-> !busy_drv_lo_o); // R8
   AST_PAD_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(busy_drv_lo_o && busy_drv_hi_o)); // R9
   AST_HIGH_AFTER_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(xfer_run_o) && !$past(xfer_dir_o)) |-> busy_drv_hi_o); // R9
   AST_LATCH_CLEAR_AFTER_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(xfer_run_o) |-> !dirty_o); // R10
   AST_PF_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && !ase_q && !sw_store_i) |=> !xfer_run_o); // R4
   AST_SW_ALWAYS_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && sw_store_i) |=> (xfer_run_o && !xfer_dir_o)); // R5
   AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_STORE && !tmr_zero) |=> (state_q == ST_STORE)); // R11

endmodule

// File: tb/nv_xfer_seq_bench.sv
module nv_xfer_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int D = 3;
   localparam int S = 5;
   localparam int R = 4;
   localparam int H = 2;
   localparam int Y = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_fail = 1'b0, sw_store = 1'b0, ext_lo = 1'b0;
   logic ase_wr = 1'b0, ase_wd = 1'b0;
   logic req = 1'b0, we = 1'b0;
   logic drv_lo, drv_hi, ase, gnt, dirty, run, dir;
   logic busy_pin;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign busy_pin = (ext_lo || drv_lo) ? 1'b0 : 1'b1;

   nv_xfer_seq #(
      .DELAY_CYC(D), .STORE_CYC(S), .RECALL_CYC(R), .HIGH_CYC(H),
      .SYNC_STAGES(Y), .ASE_RST(1'b1)
   ) u_nv_xfer_seq (
      .clk_i(clk), .rst_ni(rst_n), .pwr_fail_i(pwr_fail), .sw_store_i(sw_store),
      .busy_pin_i(busy_pin), .busy_drv_lo_o(drv_lo), .busy_drv_hi_o(drv_hi),
      .ase_wr_i(ase_wr), .ase_wdata_i(ase_wd), .ase_o(ase),
      .host_req_i(req), .host_we_i(we), .host_gnt_o(gnt), .dirty_o(dirty),
      .xfer_run_o(run), .xfer_dir_o(dir)
   );

   task automatic chk(input string rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic tick;
      @(negedge clk);
   endtask

   // entered with the trigger set at the current negedge
   task automatic run_store(input string rq, input bit exp_lo, input bit inject);
      for (int i = 0; i < S; i++) begin
         tick;
         if (i == 0) begin pwr_fail = 1'b0; sw_store = 1'b0; end
         chk(rq, {run, dir}, 2'b10);
         chk("R2", gnt, 0);
         chk("R8", drv_lo, exp_lo);
         if (inject && i == 1) sw_store = 1'b1;
         if (inject && i == 2) sw_store = 1'b0;
      end
      for (int i = 0; i < H; i++) begin
         tick;
         chk("R9", drv_hi, 1);
         chk("R10", dirty, 0);
         chk(rq, run, 0);
      end
      tick;
      chk("R9", drv_hi, 0);
   endtask

   task automatic do_write;
      we = 1'b1;
      #1 chk("R3", gnt, 1);
      tick;
      we = 1'b0;
      chk("R3", dirty, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      req = 1'b1;
      repeat (3) tick;
      // R1 R2 R12: reset state
      chk("R1", {run, dir}, 2'b11);
      chk("R2", gnt, 0);
      chk("R12", ase, 1);
      chk("R8", drv_lo, 0);
      chk("R9", drv_hi, 0);
      rst_n = 1'b1;
      for (int i = 0; i < R - 1; i++) begin
         tick;
         chk("R1", {run, dir}, 2'b11);
         chk("R2", gnt, 0);
      end
      tick;
      chk("R1", run, 0);
      chk("R10", dirty, 0);
      chk("R3", gnt, 1);
      chk("R9", drv_hi, 0);

      // R3: read leaves latch, write sets it
      tick;
      chk("R3", dirty, 0);
      do_write;

      // R4: supply-fail with latch set
      pwr_fail = 1'b1;
      run_store("R4", 1'b1, 1'b0);
      chk("R10", dirty, 0);

      // R4: supply-fail with latch clear is ignored
      pwr_fail = 1'b1;
      for (int i = 0; i < 4; i++) begin tick; chk("R4", run, 0); end
      pwr_fail = 1'b0;

      // R12 R4: auto-store disabled
      ase_wr = 1'b1; ase_wd = 1'b0;
      tick;
      ase_wr = 1'b0;
      chk("R12", ase, 0);
      do_write;
      pwr_fail = 1'b1;
      for (int i = 0; i < 4; i++) begin tick; chk("R4", run, 0); chk("R4", dirty, 1); end
      pwr_fail = 1'b0;
      ase_wr = 1'b1; ase_wd = 1'b1;
      tick;
      ase_wr = 1'b0;
      chk("R12", ase, 1);

      // R11: simultaneous triggers give a single store
      pwr_fail = 1'b1; sw_store = 1'b1;
      run_store("R11", 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) begin tick; chk("R11", run, 0); end

      // R5: software store with latch clear, mid-store trigger dropped (R11)
      chk("R5", dirty, 0);
      sw_store = 1'b1;
      run_store("R5", 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) begin tick; chk("R11", run, 0); end

      // R6 R7 R8: pad request with latch set
      do_write;
      ext_lo = 1'b1; we = 1'b1;
      #1 chk("R7", gnt, 1);
      tick;
      chk("R7", gnt, 1);
      tick;
      chk("R7", gnt, 0);
      we = 1'b0;
      #1 chk("R7", gnt, 1);
      chk("R6", run, 0);
      for (int i = 0; i < D; i++) begin
         tick;
         chk("R6", run, 0);
         chk("R8", drv_lo, 1);
         chk("R7", gnt, 1);
      end
      run_store("R6", 1'b1, 1'b0);
      // pad still held low, latch clear: nothing starts
      for (int i = 0; i < 3; i++) begin
         tick;
         chk("R6", run, 0);
         chk("R8", drv_lo, 0);
      end
      we = 1'b1;
      #1 chk("R7", gnt, 0);
      ext_lo = 1'b0;
      tick;
      chk("R7", gnt, 0);
      tick;
      chk("R7", gnt, 1);
      we = 1'b0;
      req = 1'b0;
      tick;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule